// File: doc/BRIEF.md
# Port Pin-Change Interrupt Unit

This block watches three general-purpose input ports, 8, 7 and 8 pins wide, and turns input activity into five interrupt request lines. Each port has one shared flag. Any transition on any of its unmasked pins sets that flag. The flag does not record which pin moved, so the handler must work that out itself. Two pins of the third port also serve as dedicated external sources. Each of these has its own flag, its own enable and a selectable sense mode.

Every pin first passes through a two-flop synchronizer. Edges are then found by comparing the synchronized value with the sample taken one cycle earlier. Flags latch whether or not their request is enabled. Software clears flags by writing ones. The flag of a dedicated source also clears when its vector is acknowledged. The five requests have a fixed ranking, and a one-hot grant names the highest-ranked active request.

Top module: `pcint_unit`

## Requirements
- R1: After reset, all flags, requests and grants are 0, and the synchronized pin history is 0.
- R2: A change in either direction on any port pin whose mask bit is 1 sets that port's flag (flag bit 2 for port B, bit 3 for port C, bit 4 for port D). A change on a pin whose mask bit is 0 leaves the flag unchanged.
- R3: A pin change that is stable before rising edge E becomes visible in the flags after the second rising edge following E. The combinational low-level request follows the pin after the first rising edge following E.
- R4: `port_en[p]` gates only the request `irq_req[2+p]`. The port flag latches whether or not the port is enabled.
- R5: Each dedicated source decodes its 2-bit sense field as follows: 00 is low level, 01 is any change, 10 is falling edge only and 11 is rising edge only. In the three edge modes, the flag (bit 0 for external 0, bit 1 for external 1) latches whether or not `ext_en` is set, and the request is the flag ANDed with the enable.
- R6: In low-level mode, the request equals `ext_en` ANDed with the inverted synchronized pin, and the source's flag is never set.
- R7: A pulse on `vec_ack[0]` or `vec_ack[1]` clears the matching dedicated flag. Pulses on `vec_ack[4:2]` leave the port flags unchanged.
- R8: When `flag_clr_wr` is 1, each 1 in `flag_clr_data` clears the flag at the same bit position. If a new event arrives in the same cycle, the flag stays set.
- R9: The ranking is fixed with bit 0 highest: external 0, external 1, port B, port C, port D. `irq_grant` is one-hot on the lowest-numbered active request, or 0 when no request is active.
- R10: The dedicated pins are bits 2 and 3 of port D. A change on them also feeds the port D flag, subject to `mask_d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_b | input | 8 | Raw port B pins |
| pin_c | input | 7 | Raw port C pins |
| pin_d | input | 8 | Raw port D pins; bits 2 and 3 are also the dedicated sources |
| mask_b | input | 8 | Per-pin change mask for port B, 1 = watched |
| mask_c | input | 7 | Per-pin change mask for port C |
| mask_d | input | 8 | Per-pin change mask for port D |
| port_en | input | 3 | Request enables for ports B, C, D |
| ext_en | input | 2 | Request enables for external 0 and 1 |
| ext0_sense | input | 2 | Sense mode of external 0 |
| ext1_sense | input | 2 | Sense mode of external 1 |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr_data | input | 5 | Write-one-to-clear bit map |
| vec_ack | input | 5 | Vector acknowledge strobes |
| flags | output | 5 | Latched flags |
| irq_req | output | 5 | Request lines, bit 0 highest |
| irq_grant | output | 5 | One-hot highest active request |

## Verification
A flag that is wrongly set or wrongly cleared shows up on `flags` at the next sample. It also shows up on `irq_req` and `irq_grant` as soon as the matching enable is on. A corrupted synchronizer history has two visible effects. Extra or missing flag sets appear two edges after the pin moves. The low-level request appears one edge after the pin moves. The bench keeps a behavioural pin-history model and compares all three outputs every cycle, so any such divergence is reported in the cycle it first appears.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int NUM_SRC  = 5;
  localparam int NUM_PORT = 3;
  localparam int SRC_EXT0 = 0;
  localparam int SRC_EXT1 = 1;
  localparam int SRC_PORT = 2;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
  parameter int W      = 23,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign cur  = stage_q[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/pcint_port_flag.sv
module pcint_port_flag #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] mask,
  input  logic         clr,
  output logic         flag
);
  logic hit;
  logic flag_d, flag_q;

  always_comb begin
    hit    = |((cur ^ prev) & mask);
    flag_d = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/pcint_ext_src.sv
module pcint_ext_src
  import pcint_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cur,
  input  logic       prev,
  input  logic [1:0] sense,
  input  logic       en,
  input  logic       clr,
  input  logic       ack,
  output logic       flag,
  output logic       req
);
  logic hit;
  logic flag_d, flag_q;

  always_comb begin
    unique case (sense)
      SENSE_ANY:  hit = cur ^ prev;
      SENSE_FALL: hit = prev & ~cur;
      SENSE_RISE: hit = cur & ~prev;
      default:    hit = 1'b0;
    endcase
    flag_d = hit | (flag_q & ~(clr | ack));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    if (sense == SENSE_LOW) req = en & ~cur;
    else                    req = en & flag_q;
  end

  assign flag = flag_q;
endmodule

// File: rtl/pcint_prio.sv
module pcint_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcint_unit.sv
module pcint_unit
  import pcint_pkg::*;
#(
  parameter int PB_W     = 8,
  parameter int PC_W     = 7,
  parameter int PD_W     = 8,
  parameter int EXT0_BIT = 2,
  parameter int EXT1_BIT = 3,
  parameter int SYNC_STG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PB_W-1:0] pin_b,
  input  logic [PC_W-1:0] pin_c,
  input  logic [PD_W-1:0] pin_d,
  input  logic [PB_W-1:0] mask_b,
  input  logic [PC_W-1:0] mask_c,
  input  logic [PD_W-1:0] mask_d,
  input  logic [2:0]      port_en,
  input  logic [1:0]      ext_en,
  input  logic [1:0]      ext0_sense,
  input  logic [1:0]      ext1_sense,
  input  logic            flag_clr_wr,
  input  logic [4:0]      flag_clr_data,
  input  logic [4:0]      vec_ack,
  output logic [4:0]      flags,
  output logic [4:0]      irq_req,
  output logic [4:0]      irq_grant
);
  localparam int NPIN  = PB_W + PC_W + PD_W;
  localparam int OFF_D = PB_W + PC_W;
  localparam int E0    = OFF_D + EXT0_BIT;
  localparam int E1    = OFF_D + EXT1_BIT;

  function automatic int port_w(input int p);
    case (p)
      0:       return PB_W;
      1:       return PC_W;
      default: return PD_W;
    endcase
  endfunction

  function automatic int port_off(input int p);
    case (p)
      0:       return 0;
      1:       return PB_W;
      default: return OFF_D;
    endcase
  endfunction

  logic [NPIN-1:0]    pins_raw, mask_all;
  logic [NPIN-1:0]    sync_cur, sync_prev;
  logic [NUM_SRC-1:0] clr_vec, flag_vec, req_vec;
  logic [1:0]         ext_sense [2];

  assign pins_raw     = {pin_d, pin_c, pin_b};
  assign mask_all     = {mask_d, mask_c, mask_b};
  assign clr_vec      = flag_clr_wr ? flag_clr_data : '0;
  assign ext_sense[0] = ext0_sense;
  assign ext_sense[1] = ext1_sense;

  pcint_sync #(.W(NPIN), .STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pins_raw),
    .cur  (sync_cur),
    .prev (sync_prev)
  );

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    localparam int W   = port_w(p);
    localparam int OFF = port_off(p);
    pcint_port_flag #(.W(W)) u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .cur  (sync_cur[OFF +: W]),
      .prev (sync_prev[OFF +: W]),
      .mask (mask_all[OFF +: W]),
      .clr  (clr_vec[SRC_PORT+p]),
      .flag (flag_vec[SRC_PORT+p])
    );
    assign req_vec[SRC_PORT+p] = port_en[p] & flag_vec[SRC_PORT+p];
  end

  for (genvar e = 0; e < 2; e++) begin : g_ext
    localparam int BIT = (e == 0) ? E0 : E1;
    pcint_ext_src u_ext (
      .clk  (clk),
      .rst_n(rst_n),
      .cur  (sync_cur[BIT]),
      .prev (sync_prev[BIT]),
      .sense(ext_sense[e]),
      .en   (ext_en[e]),
      .clr  (clr_vec[e]),
      .ack  (vec_ack[e]),
      .flag (flag_vec[e]),
      .req  (req_vec[e])
    );
  end

  pcint_prio #(.N(NUM_SRC)) u_prio (
    .req  (req_vec),
    .grant(irq_grant)
  );

  assign flags   = flag_vec;
  assign irq_req = req_vec;
endmodule

// File: rtl/pcint_unit_chk.sv
module pcint_unit_chk #(
  parameter int PB_W = 8,
  parameter int NPIN = 23,
  parameter int E0   = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] sync_cur,
  input logic [NPIN-1:0] sync_prev,
  input logic [PB_W-1:0] mask_b,
  input logic [1:0]      ext_en,
  input logic [1:0]      ext0_sense,
  input logic            flag_clr_wr,
  input logic [4:0]      flag_clr_data,
  input logic [4:0]      vec_ack,
  input logic [4:0]      flags,
  input logic [4:0]      irq_req,
  input logic [4:0]      irq_grant
);
  logic [NPIN-1:0] moved;
  logic            b_hit;
  assign moved = sync_cur ^ sync_prev;
  assign b_hit = |(moved[PB_W-1:0] & mask_b);

  a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_grant));

  a_r9_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] |-> irq_grant[0]);

  a_r9_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |-> (|(irq_grant & irq_req)));

  a_r6_low_level_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en[0] && ext0_sense == 2'b00 && !sync_cur[E0]) |-> irq_req[0]);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack[0] && !moved[E0]) |=> !flags[0]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_wr && flag_clr_data[2] && b_hit) |=> flags[2]);

  a_r2_quiet_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_hit && !(flag_clr_wr && flag_clr_data[2])) |=> $stable(flags[2]));
endmodule

bind pcint_unit pcint_unit_chk #(.PB_W(PB_W), .NPIN(NPIN), .E0(E0)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sync_cur     (sync_cur),
  .sync_prev    (sync_prev),
  .mask_b       (mask_b),
  .ext_en       (ext_en),
  .ext0_sense   (ext0_sense),
  .flag_clr_wr  (flag_clr_wr),
  .flag_clr_data(flag_clr_data),
  .vec_ack      (vec_ack),
  .flags        (flags),
  .irq_req      (irq_req),
  .irq_grant    (irq_grant)
);

// File: tb/tb_pcint_unit.sv
module tb_pcint_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] pin_b, mask_b;
  logic [6:0] pin_c, mask_c;
  logic [7:0] pin_d, mask_d;
  logic [2:0] port_en;
  logic [1:0] ext_en, ext0_sense, ext1_sense;
  logic       flag_clr_wr;
  logic [4:0] flag_clr_data, vec_ack;
  logic [4:0] flags, irq_req, irq_grant;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  bit mon_on = 1'b0;

  always #5 clk = ~clk;

  pcint_unit dut (.*);

  // Reference model: raw pin history, newest first
  logic [22:0] h0, h1, h2;
  logic [4:0]  mflag;

  function automatic logic ext_hit(input logic [1:0] mode, input logic c, input logic p);
    case (mode)
      2'b01:   return c ^ p;
      2'b10:   return p & ~c;
      2'b11:   return c & ~p;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = '0; h1 = '0; h2 = '0; mflag = '0;
    end else begin
      logic [22:0] d;
      logic [4:0]  set, clr;
      d      = h1 ^ h2;
      set[0] = ext_hit(ext0_sense, h1[17], h2[17]);
      set[1] = ext_hit(ext1_sense, h1[18], h2[18]);
      set[2] = |(d[7:0]   & mask_b);
      set[3] = |(d[14:8]  & mask_c);
      set[4] = |(d[22:15] & mask_d);
      clr    = flag_clr_wr ? flag_clr_data : 5'b0;
      clr[0] = clr[0] | vec_ack[0];
      clr[1] = clr[1] | vec_ack[1];
      mflag  = set | (mflag & ~clr);
      h2 = h1; h1 = h0; h0 = {pin_d, pin_c, pin_b};
    end
  end

  function automatic logic [4:0] exp_req();
    logic [4:0] r;
    r[0] = ext_en[0] & ((ext0_sense == 2'b00) ? ~h1[17] : mflag[0]);
    r[1] = ext_en[1] & ((ext1_sense == 2'b00) ? ~h1[18] : mflag[1]);
    r[2] = port_en[0] & mflag[2];
    r[3] = port_en[1] & mflag[3];
    r[4] = port_en[2] & mflag[4];
    return r;
  endfunction

  function automatic logic [4:0] exp_grant(input logic [4:0] r);
    for (int i = 0; i < 5; i++) if (r[i]) return 5'(1 << i);
    return 5'b0;
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, sampled away from both edges
  always @(posedge clk) begin
    #3;
    if (mon_on && !done) begin
      chk("R2/R5/R7/R8 model flags", flags, mflag);
      chk("R4/R6 model req", irq_req, exp_req());
      chk("R9 model grant", irq_grant, exp_grant(exp_req()));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wclr(input logic [4:0] bits);
    flag_clr_wr = 1'b1; flag_clr_data = bits;
    tick(1);
    flag_clr_wr = 1'b0; flag_clr_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pin_b = '0; pin_c = '0; pin_d = '0;
    mask_b = '0; mask_c = '0; mask_d = '0;
    port_en = '0; ext_en = '0; ext0_sense = 2'b01; ext1_sense = 2'b01;
    flag_clr_wr = 1'b0; flag_clr_data = '0; vec_ack = '0;
    tick(3);
    chk("R1 reset flags", flags, 5'b0);
    chk("R1 reset req", irq_req, 5'b0);
    chk("R1 reset grant", irq_grant, 5'b0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    tick(2);

    // R3 latency, R4 disabled port still flags
    mask_b = 8'hFF;
    pin_b[1] = 1'b1;
    tick(2);
    chk("R3 not yet flagged", flags, 5'b00000);
    tick(1);
    chk("R3 flag after third edge", flags, 5'b00100);
    chk("R4 disabled port no req", irq_req, 5'b00000);
    port_en = 3'b001;
    tick(1);
    chk("R4 enable shows req", irq_req, 5'b00100);
    chk("R9 grant port B", irq_grant, 5'b00100);

    // R7 ack on a port vector does not clear; R8 w1c does
    vec_ack = 5'b00100; tick(1); vec_ack = '0; tick(1);
    chk("R7 port flag survives ack", flags, 5'b00100);
    wclr(5'b00100); tick(1);
    chk("R8 w1c clears port B", flags, 5'b00000);

    // R2 falling change also flags; masked port C ignored
    pin_b[1] = 1'b0; pin_c = 7'h55; tick(4);
    chk("R2 falling sets B, masked C quiet", flags, 5'b00100);
    wclr(5'b00100);

    // R5 rising mode on external 0, R10 feeds port D when unmasked
    ext0_sense = 2'b11; mask_d = 8'h04;
    pin_d[2] = 1'b1; tick(4);
    chk("R5/R10 rise sets ext0 and port D", flags, 5'b10001);
    vec_ack = 5'b00001; tick(1); vec_ack = '0; tick(1);
    chk("R7 ack clears ext0 only", flags, 5'b10000);
    wclr(5'b10000);
    pin_d[2] = 1'b0; mask_d = '0; tick(4);
    chk("R5 falling ignored in rise mode", flags, 5'b00000);

    // R6 low-level mode on external 1
    ext1_sense = 2'b00; ext_en = 2'b10; tick(1);
    chk("R6 low level req", irq_req, 5'b00010);
    pin_d[3] = 1'b1; tick(1);
    chk("R6 req held one edge", irq_req, 5'b00010);
    tick(1);
    chk("R6 req drops after sync", irq_req, 5'b00000);
    chk("R6 no flag in low mode", flags, 5'b00000);

    // R9 priority with several requests
    ext1_sense = 2'b01; ext_en = 2'b11; port_en = 3'b111;
    mask_c = 7'h7F; pin_c = 7'h00; pin_d[3] = 1'b0; tick(4);
    chk("R9 grant ext1 over port C", irq_grant, 5'b00010);
    wclr(5'b00010); tick(1);
    chk("R9 grant falls to port C", irq_grant, 5'b01000);
    wclr(5'b11111); tick(1);

    // R8 set wins over clear in the same cycle
    pin_b[0] = 1'b1; tick(2);
    flag_clr_wr = 1'b1; flag_clr_data = 5'b00100; tick(1);
    flag_clr_wr = 1'b0; flag_clr_data = '0;
    chk("R8 event beats clear", flags[2] ? 5'b1 : 5'b0, 5'b1);

    // randomized traffic against the model
    for (int i = 0; i < 600; i++) begin
      pin_b = 8'($urandom); pin_c = 7'($urandom); pin_d = 8'($urandom);
      if (i % 16 == 0) begin
        mask_b = 8'($urandom); mask_c = 7'($urandom); mask_d = 8'($urandom);
        port_en = 3'($urandom); ext_en = 2'($urandom);
        ext0_sense = 2'($urandom); ext1_sense = 2'($urandom);
      end
      vec_ack = ($urandom % 4 == 0) ? 5'($urandom) : 5'b0;
      flag_clr_wr = ($urandom % 3 == 0);
      flag_clr_data = 5'($urandom);
      tick(1);
    end
    vec_ack = '0; flag_clr_wr = 1'b0;
    tick(2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule